// File: doc/BRIEF.md
# MII to RMII Transmit Converter

This block sits between a MAC's 4-bit media independent transmit interface and a PHY's 2-bit reduced-pin transmit interface. All of its logic runs on the 50 MHz reference clock. An internal pacer produces a nibble strobe, `nib_stb_o`, which marks the reference-clock cycles in which the MAC's nibble is sampled. Each nibble that is sampled is sent to the PHY as two dibits, with bits 1:0 first and bits 3:2 second. The transmit enable is carried along with the nibble, so the PHY's enable covers both dibits of every nibble that was sampled while the MAC had transmit enable high.

The line rate is fixed at build time by a parameter. `SPEED_100` = 1 is the default and selects 100 Mbps: one dibit per reference clock and one nibble every two clocks. `SPEED_100` = 0 selects 10 Mbps: each dibit is held for `SLOW_DIV` (10) reference clocks and one nibble is taken every 20 clocks.

A duplex parameter, `FULL_DUPLEX`, controls the collision output. In half duplex, collision is built from transmit enable and carrier sense. In full duplex, collision is held low. A loopback parameter, `LOOPBACK`, selects the source of the receive dibit and carrier-sense/data-valid handed on to the receive path: either the PHY's receive pins or the block's own transmit outputs.

Top module: `rmii_tx_conv`

## Requirements
- R1: While rst_ni is low, rmii_txen_o is 0 and rmii_txd_o is 2'b00.
- R2: With SPEED_100=1, nib_stb_o is high on every second reference clock. A nibble present on mii_txd_i in a cycle with nib_stb_o high appears as bits 1:0 on rmii_txd_o in the next cycle and as bits 3:2 in the cycle after that.
- R3: With SPEED_100=0, nib_stb_o is high once every 20 reference clocks. After the sampling edge, bits 1:0 are held on rmii_txd_o for 10 clocks, then bits 3:2 for the next 10 clocks.
- R4: rmii_txen_o is high for both dibits of a nibble sampled with mii_txen_i = 1. A nibble sampled with mii_txen_i = 0 gives rmii_txen_o = 0 and rmii_txd_o = 2'b00 for both dibits, whatever mii_txd_i holds.
- R5: If mii_txen_i or mii_txd_i changes between two sampling cycles, the dibit pair already in progress is not affected: the second dibit and its enable come from the nibble that was sampled.
- R6: With FULL_DUPLEX=0, mii_col_o equals mii_txen_i AND mii_crs_i, combinationally.
- R7: With FULL_DUPLEX=1, mii_col_o is 0 even when mii_txen_i and mii_crs_i are both 1.
- R8: With LOOPBACK=0, rx_dibit_o equals rmii_rxd_i and rx_crsdv_o equals rmii_crsdv_i.
- R9: With LOOPBACK=1, rx_dibit_o equals rmii_txd_o and rx_crsdv_o equals rmii_txen_o, and rmii_rxd_i and rmii_crsdv_i have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mii_txd_i | input | 4 | Transmit nibble from the MAC |
| mii_txen_i | input | 1 | Transmit enable from the MAC |
| mii_crs_i | input | 1 | Carrier sense, used for collision |
| nib_stb_o | output | 1 | High in the cycle whose closing edge samples the nibble |
| mii_col_o | output | 1 | Collision to the MAC |
| rmii_txd_o | output | 2 | Transmit dibit to the PHY |
| rmii_txen_o | output | 1 | Transmit enable to the PHY |
| rmii_rxd_i | input | 2 | Receive dibit from the PHY |
| rmii_crsdv_i | input | 1 | Carrier-sense/data-valid from the PHY |
| rx_dibit_o | output | 2 | Receive dibit passed to the receive path |
| rx_crsdv_o | output | 1 | Carrier-sense/data-valid passed to the receive path |

## Verification
The main risk is a pacer phase that drifts against the serializer. That fault shows at the ports within one nibble period: the two dibits come out swapped, or the nibble strobe loses its period of 2 (or 20) clocks. At the slow rate, a hold counter that is off by one changes the output one clock early or late, so the bench checks every clock of the 20-clock nibble window. A wrongly captured enable shows up as a pair whose second dibit runs on after the MAC has dropped transmit enable, or as a pair cut short. This is visible in the very next cycle.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;
  localparam int NIB_W        = 4;
  localparam int DIB_W        = 2;
  localparam int SLOW_DIV_DEF = 10;

  typedef logic [NIB_W-1:0] nibble_t;
  typedef logic [DIB_W-1:0] dibit_t;
endpackage

// File: rtl/rmii_tx_pacer.sv
module rmii_tx_pacer #(
  parameter int DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic ph_o,
  output logic nib_stb_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;

  assign tick_o    = (cnt_q == LAST);
  assign ph_o      = ph_q;
  assign nib_stb_o = tick_o & ~ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (tick_o) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: hold counter never leaves its range
  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer
  import rmii_tx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    ph_i,
  input  nibble_t txd_i,
  input  logic    txen_i,
  output dibit_t  rmii_txd_o,
  output logic    rmii_txen_o
);
  dibit_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rmii_txd_o  <= '0;
      rmii_txen_o <= 1'b0;
      hold_q      <= '0;
    end else if (tick_i) begin
      if (!ph_i) begin
        rmii_txen_o <= txen_i;
        rmii_txd_o  <= txen_i ? txd_i[1:0] : '0;
        hold_q      <= txen_i ? txd_i[3:2] : '0;
      end else begin
        rmii_txd_o  <= hold_q;
      end
    end
  end

  // R5: enable never changes inside a pair
  a_r5_pair_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_i |=> $stable(rmii_txen_o));
  // R3: dibit only moves on a pacer tick
  a_r3_dibit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(rmii_txd_o));
  // R4: idle line carries zeros
  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rmii_txen_o |-> (rmii_txd_o == '0));
endmodule

// File: rtl/rmii_tx_side.sv
module rmii_tx_side
  import rmii_tx_pkg::*;
#(
  parameter bit FULL_DUPLEX = 1'b1,
  parameter bit LOOPBACK    = 1'b0
) (
  input  logic   mii_txen_i,
  input  logic   mii_crs_i,
  output logic   mii_col_o,
  input  dibit_t rmii_txd_i,
  input  logic   rmii_txen_i,
  input  dibit_t rmii_rxd_i,
  input  logic   rmii_crsdv_i,
  output dibit_t rx_dibit_o,
  output logic   rx_crsdv_o
);
  assign mii_col_o  = !FULL_DUPLEX && mii_txen_i && mii_crs_i;
  assign rx_dibit_o = LOOPBACK ? rmii_txd_i  : rmii_rxd_i;
  assign rx_crsdv_o = LOOPBACK ? rmii_txen_i : rmii_crsdv_i;
endmodule

// File: rtl/rmii_tx_conv.sv
module rmii_tx_conv
  import rmii_tx_pkg::*;
#(
  parameter bit SPEED_100   = 1'b1,
  parameter bit FULL_DUPLEX = 1'b1,
  parameter bit LOOPBACK    = 1'b0,
  parameter int SLOW_DIV    = SLOW_DIV_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mii_txd_i,
  input  logic       mii_txen_i,
  input  logic       mii_crs_i,
  output logic       nib_stb_o,
  output logic       mii_col_o,
  output logic [1:0] rmii_txd_o,
  output logic       rmii_txen_o,
  input  logic [1:0] rmii_rxd_i,
  input  logic       rmii_crsdv_i,
  output logic [1:0] rx_dibit_o,
  output logic       rx_crsdv_o
);
  localparam int DIV = SPEED_100 ? 1 : SLOW_DIV;

  logic tick, ph;

  rmii_tx_pacer #(.DIV(DIV)) u_pacer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_o    (tick),
    .ph_o      (ph),
    .nib_stb_o (nib_stb_o)
  );

  rmii_tx_serializer u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .ph_i        (ph),
    .txd_i       (mii_txd_i),
    .txen_i      (mii_txen_i),
    .rmii_txd_o  (rmii_txd_o),
    .rmii_txen_o (rmii_txen_o)
  );

  rmii_tx_side #(.FULL_DUPLEX(FULL_DUPLEX), .LOOPBACK(LOOPBACK)) u_side (
    .mii_txen_i   (mii_txen_i),
    .mii_crs_i    (mii_crs_i),
    .mii_col_o    (mii_col_o),
    .rmii_txd_i   (rmii_txd_o),
    .rmii_txen_i  (rmii_txen_o),
    .rmii_rxd_i   (rmii_rxd_i),
    .rmii_crsdv_i (rmii_crsdv_i),
    .rx_dibit_o   (rx_dibit_o),
    .rx_crsdv_o   (rx_crsdv_o)
  );

  // R6: collision only with both transmit and carrier active
  a_r6_col_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mii_col_o |-> (mii_txen_i && mii_crs_i));
endmodule

// File: tb/rmii_tx_conv_tb.sv
module rmii_tx_conv_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  logic [3:0] f_txd = '0, s_txd = '0;
  logic       f_txen = 1'b0, s_txen = 1'b0, f_crs = 1'b0, s_crs = 1'b0;
  logic [1:0] f_rxd = '0, s_rxd = '0;
  logic       f_crsdv = 1'b0, s_crsdv = 1'b0;
  logic       f_stb, s_stb, f_col, s_col, f_ten, s_ten, f_lcv, s_lcv;
  logic [1:0] f_td, s_td, f_lrx, s_lrx;

  rmii_tx_conv u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mii_txd_i(f_txd), .mii_txen_i(f_txen),
    .mii_crs_i(f_crs), .nib_stb_o(f_stb), .mii_col_o(f_col),
    .rmii_txd_o(f_td), .rmii_txen_o(f_ten), .rmii_rxd_i(f_rxd),
    .rmii_crsdv_i(f_crsdv), .rx_dibit_o(f_lrx), .rx_crsdv_o(f_lcv)
  );

  rmii_tx_conv #(.SPEED_100(1'b0), .FULL_DUPLEX(1'b0), .LOOPBACK(1'b1)) u_dut_slow (
    .clk_i(clk), .rst_ni(rst_ni), .mii_txd_i(s_txd), .mii_txen_i(s_txen),
    .mii_crs_i(s_crs), .nib_stb_o(s_stb), .mii_col_o(s_col),
    .rmii_txd_o(s_td), .rmii_txen_o(s_ten), .rmii_rxd_i(s_rxd),
    .rmii_crsdv_i(s_crsdv), .rx_dibit_o(s_lrx), .rx_crsdv_o(s_lcv)
  );

  // {txen, nibble}
  localparam logic [4:0] VEC [0:7] = '{5'h15, 5'h15, 5'h1D, 5'h1E,
                                       5'h10, 5'h1F, 5'h0C, 5'h00};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fast_nib(input logic en, input logic [3:0] d);
    while (!f_stb) @(negedge clk);
    f_txen = en;
    f_txd  = d;
    @(negedge clk);
    chk("R2 lo dibit", int'(f_td), int'(en ? d[1:0] : 2'b00));
    chk("R4 txen lo", int'(f_ten), int'(en));
    chk("R2 stb off", int'(f_stb), 0);
    @(negedge clk);
    chk("R2 hi dibit", int'(f_td), int'(en ? d[3:2] : 2'b00));
    chk("R4 txen hi", int'(f_ten), int'(en));
    chk("R2 stb period", int'(f_stb), 1);
  endtask

  task automatic slow_nib(input logic en, input logic [3:0] d);
    while (!s_stb) @(negedge clk);
    s_txen = en;
    s_txd  = d;
    for (int k = 1; k <= 20; k++) begin
      logic [1:0] e;
      @(negedge clk);
      e = !en ? 2'b00 : (k <= 10) ? d[1:0] : d[3:2];
      chk("R3 dibit hold", int'(s_td), int'(e));
      chk("R4 slow txen", int'(s_ten), int'(en));
      chk("R9 loop dibit", int'(s_lrx), int'(e));
      chk("R9 loop crsdv", int'(s_lcv), int'(en));
      chk("R3 stb period", int'(s_stb), (k == 20) ? 1 : 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    f_txen = 1'b1; f_txd = 4'hF; s_txen = 1'b1; s_txd = 4'hF;
    repeat (3) @(negedge clk);
    chk("R1 fast txen", int'(f_ten), 0);
    chk("R1 fast txd", int'(f_td), 0);
    chk("R1 slow txen", int'(s_ten), 0);
    chk("R1 slow txd", int'(s_td), 0);
    f_txen = 1'b0; f_txd = '0; s_txen = 1'b0; s_txd = '0;
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R4 table walk
    for (int i = 0; i < 8; i++) fast_nib(VEC[i][4], VEC[i][3:0]);

    // R5: enable drop mid-pair does not cut the pair
    while (!f_stb) @(negedge clk);
    f_txen = 1'b1; f_txd = 4'hB;
    @(negedge clk);
    chk("R5 lo dibit", int'(f_td), 3);
    f_txen = 1'b0; f_txd = 4'h0;
    @(negedge clk);
    chk("R5 hi dibit kept", int'(f_td), 2);
    chk("R5 txen kept", int'(f_ten), 1);
    fast_nib(1'b0, 4'h0);

    // R7 full duplex collision
    f_txen = 1'b1; f_crs = 1'b1; #1;
    chk("R7 col low", int'(f_col), 0);
    f_txen = 1'b0; f_crs = 1'b0;

    // R8 passthrough
    f_rxd = 2'b10; f_crsdv = 1'b1; #1;
    chk("R8 rx dibit", int'(f_lrx), 2);
    chk("R8 rx crsdv", int'(f_lcv), 1);
    f_rxd = 2'b01; f_crsdv = 1'b0; #1;
    chk("R8 rx dibit", int'(f_lrx), 1);
    chk("R8 rx crsdv", int'(f_lcv), 0);

    // R6 half duplex collision
    s_txen = 1'b1; s_crs = 1'b1; #1;
    chk("R6 col high", int'(s_col), 1);
    s_crs = 1'b0; #1;
    chk("R6 col crs off", int'(s_col), 0);
    s_txen = 1'b0; s_crs = 1'b1; #1;
    chk("R6 col txen off", int'(s_col), 0);
    s_crs = 1'b0;
    @(negedge clk);

    // R3 R9: slow rate with PHY inputs driven against the loopback
    s_rxd = 2'b11; s_crsdv = 1'b0;
    slow_nib(1'b1, 4'h6);
    s_rxd = 2'b00; s_crsdv = 1'b1;
    slow_nib(1'b1, 4'h9);
    slow_nib(1'b0, 4'h7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule